// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds the working registers of a 16-bit execution datapath. There are eight word registers. The first four are general registers. Each of them can also be reached as two separate byte registers, a high byte and a low byte. The other four are pointer and index registers, and they are reached only as whole words. Two read ports and one write port serve the datapath. Each port takes a 3-bit register code and a size bit that picks byte or word access. The read ports are combinational, so a value written at a clock edge can be read in the next cycle.

A second write port loads the multiply/divide pair in one cycle from a 32-bit value. Two outputs are always live and need no read port. The first is the loop-count register. The second is the 32-bit concatenation of the high-result register and the accumulator.

Top module: `gpr_bank`

## Requirements
- R1: While `rst_n` is low, every register is cleared to zero. After reset, every read returns zero until a register is written.
- R2: In word mode (size bit 0), codes 0 to 7 select the word registers in this order: accumulator A, count C, data D, base B, stack pointer, base pointer, source index, destination index.
- R3: In byte mode (size bit 1), codes 0 to 3 select the low bytes of A, C, D and B. Codes 4 to 7 select the high bytes of A, C, D and B. A byte read returns the byte in bits 7:0, and bits 15:8 are zero.
- R4: A byte write changes only the addressed half of its word register. The other half of that word keeps its value.
- R5: Both read ports decode their codes independently. A read in the same cycle as a write to the same register returns the old value. The new value is visible after the clock edge.
- R6: `count_q` always shows register C.
- R7: `wide_q` always shows D in bits 31:16 and A in bits 15:0.
- R8: When `wide_en` is high, D takes `wide_data[31:16]` and A takes `wide_data[15:0]` at the clock edge.
- R9: When a wide load and a normal write hit the same cycle, the normal write takes the bytes it addresses. Every other byte of A and D takes the wide load value.
- R10: When `wr_en` and `wide_en` are both low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd0_code | input | 3 | Read port 0 register code |
| rd0_byte | input | 1 | Read port 0 byte-mode select |
| rd0_data | output | 16 | Read port 0 data |
| rd1_code | input | 3 | Read port 1 register code |
| rd1_byte | input | 1 | Read port 1 byte-mode select |
| rd1_data | output | 16 | Read port 1 data |
| wr_en | input | 1 | Write port enable |
| wr_code | input | 3 | Write port register code |
| wr_byte | input | 1 | Write port byte-mode select |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| wide_en | input | 1 | Wide pair load enable |
| wide_data | input | 32 | Wide pair load value, D in the upper half |
| count_q | output | 16 | Live count register C |
| wide_q | output | 32 | Live pair, D upper and A lower |

## Verification
Two functions can act in the same cycle: the wide pair load and a normal write. They can hit A or D as a whole word, as a single byte, or not at all. Random stimulus turns on both enables together often. Directed cases also pair a wide load with a high-byte write to A and with a word write to D. The resulting bytes are judged against a bench model that applies the wide load first and then the normal write. Each outcome is checked through `wide_q` and through both read ports in the following cycle.

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            rd0_code,
  input  logic                  rd0_byte,
  output logic [WORD_W-1:0]     rd0_data,
  input  logic [2:0]            rd1_code,
  input  logic                  rd1_byte,
  output logic [WORD_W-1:0]     rd1_data,
  input  logic                  wr_en,
  input  logic [2:0]            wr_code,
  input  logic                  wr_byte,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  wide_en,
  input  logic [2*WORD_W-1:0]   wide_data,
  output logic [WORD_W-1:0]     count_q,
  output logic [2*WORD_W-1:0]   wide_q
);
  localparam int HALF   = WORD_W / 2;
  localparam int NREG   = 8;
  localparam int PAIRS  = 4;
  localparam int CODE_W = 3;
  localparam int IDX_A  = 0;
  localparam int IDX_C  = 1;
  localparam int IDX_D  = 2;

  logic [WORD_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [WORD_W-1:0] q;
    logic [HALF-1:0]   lo_nx, hi_nx;
    logic              word_sel, lo_sel, hi_sel, wide_sel;
    logic [WORD_W-1:0] wide_part;

    assign word_sel = wr_en && !wr_byte && (wr_code == CODE_W'(g));

    if (g < PAIRS) begin : g_alias
      assign lo_sel = wr_en && wr_byte && (wr_code == CODE_W'(g));
      assign hi_sel = wr_en && wr_byte && (wr_code == CODE_W'(g + PAIRS));
    end else begin : g_plain
      assign lo_sel = 1'b0;
      assign hi_sel = 1'b0;
    end

    if (g == IDX_A) begin : g_wlo
      assign wide_sel  = wide_en;
      assign wide_part = wide_data[WORD_W-1:0];
    end else if (g == IDX_D) begin : g_whi
      assign wide_sel  = wide_en;
      assign wide_part = wide_data[2*WORD_W-1:WORD_W];
    end else begin : g_wnone
      assign wide_sel  = 1'b0;
      assign wide_part = '0;
    end

    always_comb begin
      lo_nx = q[HALF-1:0];
      hi_nx = q[WORD_W-1:HALF];
      if (wide_sel) begin
        lo_nx = wide_part[HALF-1:0];
        hi_nx = wide_part[WORD_W-1:HALF];
      end
      if (word_sel || lo_sel) lo_nx = wr_data[HALF-1:0];
      if (word_sel)           hi_nx = wr_data[WORD_W-1:HALF];
      if (hi_sel)             hi_nx = wr_data[HALF-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= {hi_nx, lo_nx};
    end

    assign regs[g] = q;
  end

  logic [WORD_W-1:0] rd0_word, rd1_word;

  assign rd0_word = regs[rd0_byte ? {1'b0, rd0_code[1:0]} : rd0_code];
  assign rd1_word = regs[rd1_byte ? {1'b0, rd1_code[1:0]} : rd1_code];

  assign rd0_data = !rd0_byte ? rd0_word :
                    {{HALF{1'b0}}, rd0_code[2] ? rd0_word[WORD_W-1:HALF] : rd0_word[HALF-1:0]};
  assign rd1_data = !rd1_byte ? rd1_word :
                    {{HALF{1'b0}}, rd1_code[2] ? rd1_word[WORD_W-1:HALF] : rd1_word[HALF-1:0]};

  assign count_q = regs[IDX_C];
  assign wide_q  = {regs[IDX_D], regs[IDX_A]};
endmodule

module gpr_bank_chk #(
  parameter int WORD_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            rd0_code,
  input logic                  rd0_byte,
  input logic [WORD_W-1:0]     rd0_data,
  input logic [2:0]            rd1_code,
  input logic                  rd1_byte,
  input logic [WORD_W-1:0]     rd1_data,
  input logic                  wr_en,
  input logic [2:0]            wr_code,
  input logic                  wr_byte,
  input logic [WORD_W-1:0]     wr_data,
  input logic                  wide_en,
  input logic [2*WORD_W-1:0]   wide_data,
  input logic [WORD_W-1:0]     count_q,
  input logic [2*WORD_W-1:0]   wide_q
);
  localparam int HALF = WORD_W / 2;

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (count_q == '0) && (wide_q == '0));

  a_r3_byte_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_byte |-> (rd0_data[WORD_W-1:HALF] == '0));

  a_r4_low_byte_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && wr_code == 3'd0 && !wide_en) |=>
      (wide_q[WORD_W-1:HALF] == $past(wide_q[WORD_W-1:HALF])) &&
      (wide_q[HALF-1:0] == $past(wr_data[HALF-1:0])));

  a_r5_read_port_sees_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd1_byte && rd1_code == 3'd1) |-> (rd1_data == count_q));

  a_r6_count_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_byte && wr_code == 3'd1) |=> (count_q == $past(wr_data)));

  a_r8_wide_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_en && !wr_en) |=> (wide_q == $past(wide_data)));

  a_r9_collision_high_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_en && wr_en && wr_byte && wr_code == 3'd4) |=>
      (wide_q[WORD_W-1:HALF] == $past(wr_data[HALF-1:0])) &&
      (wide_q[HALF-1:0] == $past(wide_data[HALF-1:0])) &&
      (wide_q[2*WORD_W-1:WORD_W] == $past(wide_data[2*WORD_W-1:WORD_W])));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !wide_en) |=> $stable(wide_q) && $stable(count_q));
endmodule

bind gpr_bank gpr_bank_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/test_gpr_bank.sv
module test_gpr_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rd0_code = '0, rd1_code = '0, wr_code = '0;
  logic        rd0_byte = 1'b0, rd1_byte = 1'b0, wr_byte = 1'b0;
  logic        wr_en = 1'b0, wide_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [31:0] wide_data = '0;
  logic [15:0] rd0_data, rd1_data, count_q;
  logic [31:0] wide_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_bank i_gpr_bank (
    .clk(clk), .rst_n(rst_n),
    .rd0_code(rd0_code), .rd0_byte(rd0_byte), .rd0_data(rd0_data),
    .rd1_code(rd1_code), .rd1_byte(rd1_byte), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_code(wr_code), .wr_byte(wr_byte), .wr_data(wr_data),
    .wide_en(wide_en), .wide_data(wide_data),
    .count_q(count_q), .wide_q(wide_q)
  );

  function automatic logic [15:0] model_read(input logic [2:0] code, input logic byt);
    logic [15:0] w;
    if (!byt) return m[code];
    w = m[{1'b0, code[1:0]}];
    return code[2] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic model_update();
    if (wide_en) begin
      m[0] = wide_data[15:0];
      m[2] = wide_data[31:16];
    end
    if (wr_en) begin
      if (!wr_byte) m[wr_code] = wr_data;
      else if (wr_code[2]) m[{1'b0, wr_code[1:0]}][15:8] = wr_data[7:0];
      else m[{1'b0, wr_code[1:0]}][7:0] = wr_data[7:0];
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string ctx);
    logic [15:0] e0, e1;
    e0 = model_read(rd0_code, rd0_byte);
    e1 = model_read(rd1_code, rd1_byte);
    check(rd0_data === e0, rd0_byte ? {"R3 R5 port0 byte ", ctx} : {"R2 R5 port0 word ", ctx}, 32'(rd0_data), 32'(e0));
    check(rd1_data === e1, rd1_byte ? {"R3 R5 port1 byte ", ctx} : {"R2 R5 port1 word ", ctx}, 32'(rd1_data), 32'(e1));
    check(count_q === m[1], {"R6 count ", ctx}, 32'(count_q), 32'(m[1]));
    check(wide_q === {m[2], m[0]}, {"R7 pair ", ctx}, wide_q, {m[2], m[0]});
  endtask

  task automatic step(input bit we, input logic [2:0] wc, input bit wb, input logic [15:0] wd,
                      input bit de, input logic [31:0] dd,
                      input logic [2:0] c0, input bit b0, input logic [2:0] c1, input bit b1,
                      input string ctx);
    @(negedge clk);
    wr_en = we; wr_code = wc; wr_byte = wb; wr_data = wd;
    wide_en = de; wide_data = dd;
    rd0_code = c0; rd0_byte = b0; rd1_code = c1; rd1_byte = b1;
    #1;
    check_outputs(ctx);
    model_update();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 8; i++) m[i] = '0;
    rst_n = 1'b0;
    wr_en = 1'b1; wr_code = 3'd1; wr_data = 16'hFFFF;
    wide_en = 1'b1; wide_data = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wide_en = 1'b0;
    rst_n = 1'b1;
    for (int r = 0; r < 8; r++) begin
      rd0_code = 3'(r); rd0_byte = 1'b0; #1;
      check(rd0_data === 16'h0, "R1 reset word", 32'(rd0_data), 32'h0);
    end
    check(wide_q === 32'h0, "R1 reset pair", wide_q, 32'h0);

    for (int r = 0; r < 8; r++)
      step(1'b1, 3'(r), 1'b0, 16'h1000 + 16'(r) * 16'h0111, 1'b0, '0, 3'(r), 1'b0, 3'(r), 1'b0, "fill");
    step(1'b0, 3'd0, 1'b0, '0, 1'b0, '0, 3'd2, 1'b0, 3'd7, 1'b0, "fill readback");
    check(rd0_data === 16'h1222, "R2 code 2 is D", 32'(rd0_data), 32'h1222);
    check(rd1_data === 16'h1777, "R2 code 7 is DI", 32'(rd1_data), 32'h1777);

    step(1'b1, 3'd4, 1'b1, 16'h00AB, 1'b0, '0, 3'd0, 1'b0, 3'd4, 1'b1, "byte write AH");
    check(rd1_data === 16'h0010, "R5 old high byte same cycle", 32'(rd1_data), 32'h0010);
    step(1'b0, 3'd0, 1'b0, '0, 1'b0, '0, 3'd0, 1'b0, 3'd4, 1'b1, "after AH");
    check(rd0_data === 16'hAB00, "R4 AH write keeps AL", 32'(rd0_data), 32'hAB00);
    check(rd1_data === 16'h00AB, "R3 code 4 byte is AH", 32'(rd1_data), 32'h00AB);

    step(1'b1, 3'd3, 1'b1, 16'hEE5A, 1'b0, '0, 3'd3, 1'b0, 3'd7, 1'b1, "byte write BL");
    step(1'b0, 3'd0, 1'b0, '0, 1'b0, '0, 3'd3, 1'b0, 3'd7, 1'b1, "after BL");
    check(rd0_data === 16'h135A, "R4 BL write keeps BH", 32'(rd0_data), 32'h135A);
    check(rd1_data === 16'h0013, "R3 code 7 byte is BH", 32'(rd1_data), 32'h0013);

    step(1'b0, 3'd0, 1'b0, '0, 1'b1, 32'hDEAD_BEEF, 3'd0, 1'b0, 3'd2, 1'b0, "wide load");
    step(1'b0, 3'd0, 1'b0, '0, 1'b0, '0, 3'd0, 1'b0, 3'd2, 1'b0, "after wide");
    check(wide_q === 32'hDEAD_BEEF, "R8 wide load", wide_q, 32'hDEAD_BEEF);

    step(1'b1, 3'd4, 1'b1, 16'h0077, 1'b1, 32'h1234_5678, 3'd0, 1'b0, 3'd2, 1'b0, "collide AH");
    step(1'b0, 3'd0, 1'b0, '0, 1'b0, '0, 3'd0, 1'b0, 3'd2, 1'b0, "after collide AH");
    check(wide_q === 32'h1234_7778, "R9 collision byte wins", wide_q, 32'h1234_7778);

    step(1'b1, 3'd2, 1'b0, 16'hC0DE, 1'b1, 32'hAAAA_5555, 3'd0, 1'b0, 3'd2, 1'b0, "collide D");
    step(1'b0, 3'd0, 1'b0, '0, 1'b0, '0, 3'd0, 1'b0, 3'd2, 1'b0, "after collide D");
    check(wide_q === 32'hC0DE_5555, "R9 collision word wins", wide_q, 32'hC0DE_5555);

    step(1'b0, 3'd1, 1'b0, 16'hFFFF, 1'b0, 32'hFFFF_FFFF, 3'd1, 1'b0, 3'd5, 1'b0, "idle");
    step(1'b0, 3'd0, 1'b0, '0, 1'b0, '0, 3'd1, 1'b0, 3'd5, 1'b0, "after idle");
    check(count_q === 16'h1111, "R10 idle keeps count", 32'(count_q), 32'h1111);
    check(wide_q === 32'hC0DE_5555, "R10 idle keeps pair", wide_q, 32'hC0DE_5555);

    for (int i = 0; i < N_RANDOM; i++) begin
      step(($urandom % 4) != 0, 3'($urandom), 1'($urandom), 16'($urandom),
           ($urandom % 4) == 0, $urandom,
           3'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), "random");
    end
    step(1'b0, 3'd0, 1'b0, '0, 1'b0, '0, 3'd0, 1'b0, 3'd1, 1'b0, "final");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule